// File: doc/BRIEF.md
# DRAM Initialisation and CBR Refresh Scheduler

This block keeps an asynchronous EDO DRAM alive. It brings the device up after reset and then refreshes it, using the column-before-row (CBR) sequence, so the device's own row counter picks the row. After reset it stays silent for a configurable pause. It then owes a fixed number of initialisation refresh cycles and works them off. From then on it earns one refresh credit every refresh interval. Each credit becomes one CBR cycle as soon as the bus is free.

The block shares the strobe bus with the access controller. It raises `bus_req` while it has work. It drives the row strobe, both column strobes and write enable only while `bus_gnt` is high. It keeps the request up until its cycle has ended. Write enable is always high during its cycles, so a CBR cycle can never be taken for the device's parallel test entry. When grants are held back, credits pile up in a saturating counter, and `urgent` tells the arbiter the backlog is too long.

A level request `sr_req` puts the device into self refresh through a CBR entry. The row strobe then stays low for a minimum time and for as long as the request stays high. On exit the block precharges for a set time and runs a full catch-up burst of refresh cycles. `ready` rises once the pause and the whole initialisation burst are done, and it stays high.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held, bus_req=0, ready=0, urgent=0, in_sr=0, ras_n=1, cas_n=2'b11 and we_n=1.
- R2: After reset is released, bus_req stays 0 for exactly PAUSE_CYC rising clock edges and is 1 after edge number PAUSE_CYC, with INIT_CNT refreshes owed.
- R3: The strobes leave their idle levels (ras_n=1, cas_n=2'b11) only while bus_gnt is high. bus_req stays high from the start of a cycle until it ends, and owed refreshes wait without touching the strobes while the grant is low.
- R4: Every cycle is CBR ordered. Both bits of cas_n go low SETUP_CYC cycles before ras_n falls and stay low for as long as ras_n is low.
- R5: we_n is 1 at every clock edge at which ras_n or either bit of cas_n is low.
- R6: In a refresh cycle ras_n is low for exactly RASW_CYC cycles. It then stays high for at least PRE_CYC+1+SETUP_CYC cycles before it next falls.
- R7: Once ready is high, one refresh credit is added every REF_INT clock cycles. With the grant always given, successive refresh cycles start exactly REF_INT cycles apart.
- R8: ready rises one cycle after the precharge of the last initialisation refresh ends, and never falls afterwards.
- R9: urgent is 1 exactly when the number of owed refreshes is greater than URGENT_LIM.
- R10: The owed-refresh count saturates at DEBT_MAX. A credit earned on the same edge that a cycle completes is never lost, and once the grant returns exactly the owed number of cycles is run.
- R11: sr_req=1 while ready and idle starts a CBR self-refresh entry, which takes priority over owed refreshes. in_sr is high and ras_n and cas_n stay low for at least SR_MIN cycles and until sr_req falls. With an early drop of sr_req the low time is exactly SR_MIN cycles.
- R12: After self refresh, ras_n stays high for at least SR_PRE+1+SETUP_CYC cycles. Then exactly BURST_CNT refresh cycles run back to back, and the interval timer restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Strobe bus granted to this block |
| sr_req | input | 1 | Level request to hold the device in self refresh |
| bus_req | output | 1 | Request for the strobe bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 2 | Lower and upper column strobes, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| ready | output | 1 | Initialisation complete; normal traffic allowed |
| urgent | output | 1 | Owed refreshes exceed the limit |
| in_sr | output | 1 | Device is held in self refresh |

## Verification
Two events can land on one clock edge: the interval timer earning a credit, and a refresh cycle finishing its precharge. The counter must then keep its value rather than drop the new credit. To make this happen, the grant is withheld until the backlog saturates, then returned. The resulting back-to-back burst lasts longer than one interval, so credits arrive while cycles are completing. A scoreboard predicts each refresh from the requirements. It pushes one expected cycle per earned credit, capped at the saturation limit, and pops one for every row-strobe pulse it sees. A lost or extra credit therefore shows up as a mismatch or as an unexpected cycle.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int unsigned PAUSE_CYC  = 25_000_000,
  parameter int unsigned INIT_CNT   = 8,
  parameter int unsigned REF_INT    = 1950,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned RASW_CYC   = 8,
  parameter int unsigned PRE_CYC    = 5,
  parameter int unsigned SR_MIN     = 12_500,
  parameter int unsigned SR_PRE     = 14,
  parameter int unsigned BURST_CNT  = 4096,
  parameter int unsigned DEBT_MAX   = 8191,
  parameter int unsigned URGENT_LIM = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_gnt,
  input  logic       sr_req,
  output logic       bus_req,
  output logic       ras_n,
  output logic [1:0] cas_n,
  output logic       we_n,
  output logic       ready,
  output logic       urgent,
  output logic       in_sr
);
  localparam int unsigned CMAX = (PAUSE_CYC > SR_MIN) ? PAUSE_CYC : SR_MIN;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned DW   = $clog2(DEBT_MAX + 1);
  localparam int unsigned IW   = $clog2(REF_INT + 1);

  typedef enum logic [2:0] {S_WAIT, S_IDLE, S_CSU, S_RAS, S_PRE, S_SR, S_SRX} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] debt;
  logic [IW-1:0] itmr;
  logic          sr_cyc, rdy;

  wire cnt_z   = (cnt == '0);
  wire start   = (st == S_IDLE) && bus_req && bus_gnt;
  wire done    = (st == S_PRE) && cnt_z;
  wire sr_done = (st == S_SRX) && cnt_z;
  wire tick    = rdy && !sr_cyc && (itmr == IW'(REF_INT - 1));

  assign bus_req = (st != S_WAIT && st != S_IDLE) ||
                   (st == S_IDLE && (debt != '0 || (sr_req && rdy)));
  assign ras_n   = !(st == S_RAS || st == S_SR);
  assign cas_n   = {2{!(st == S_CSU || st == S_RAS || st == S_SR)}};
  assign we_n    = 1'b1;
  assign ready   = rdy;
  assign urgent  = debt > DW'(URGENT_LIM);
  assign in_sr   = (st == S_SR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_WAIT;
      cnt    <= CW'(PAUSE_CYC - 1);
      sr_cyc <= 1'b0;
    end else begin
      case (st)
        S_WAIT: if (cnt_z) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_IDLE: if (start) begin
          st     <= S_CSU;
          cnt    <= CW'(SETUP_CYC - 1);
          sr_cyc <= sr_req && rdy;
        end
        S_CSU: if (!cnt_z) cnt <= cnt - 1'b1;
          else if (sr_cyc) begin st <= S_SR;  cnt <= CW'(SR_MIN - 1);   end
          else             begin st <= S_RAS; cnt <= CW'(RASW_CYC - 1); end
        S_RAS: if (!cnt_z) cnt <= cnt - 1'b1;
          else begin st <= S_PRE; cnt <= CW'(PRE_CYC - 1); end
        S_PRE: if (!cnt_z) cnt <= cnt - 1'b1; else st <= S_IDLE;
        S_SR: if (!cnt_z) cnt <= cnt - 1'b1;
          else if (!sr_req) begin st <= S_SRX; cnt <= CW'(SR_PRE - 1); end
        S_SRX: if (!cnt_z) cnt <= cnt - 1'b1;
          else begin st <= S_IDLE; sr_cyc <= 1'b0; end
        default: st <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           debt <= '0;
    else if (st == S_WAIT && cnt_z)       debt <= DW'(INIT_CNT);
    else if (sr_done)                     debt <= DW'(BURST_CNT);
    else if (done && !tick)               debt <= debt - 1'b1;
    else if (tick && !done && debt != DW'(DEBT_MAX)) debt <= debt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sr_done) itmr <= '0;
    else if (rdy && !sr_cyc) itmr <= tick ? '0 : itmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdy <= 1'b0;
    else if (st == S_IDLE && debt == '0) rdy <= 1'b1;
  end
endmodule

module dram_refresh_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_gnt,
  input logic       sr_req,
  input logic       bus_req,
  input logic       ras_n,
  input logic [1:0] cas_n,
  input logic       we_n,
  input logic       ready,
  input logic       urgent,
  input logic       in_sr
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!bus_req && ras_n && cas_n == 2'b11 && !ready));

  p_grant_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || cas_n != 2'b11) |-> (bus_gnt && bus_req));

  p_cbr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_n) == 2'b00 && cas_n == 2'b00));

  p_we_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || cas_n != 2'b11) |-> we_n);

  p_ready_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_sr_strobes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_sr |-> (!ras_n && cas_n == 2'b00 && ready));
endmodule

bind dram_refresh_sched dram_refresh_sched_chk u_chk (.*);

// File: tb/sim_dram_refresh_sched.sv
module sim_dram_refresh_sched;
  localparam int P_PAUSE = 20, P_INIT = 8, P_INT = 60, P_SET = 1, P_RASW = 3,
                 P_PRE = 2, P_SRMIN = 10, P_SRPRE = 3, P_BURST = 5,
                 P_MAX = 12, P_LIM = 4;

  logic clk = 0, rst_n = 0, bus_gnt = 0, sr_req = 0;
  logic bus_req, ras_n, we_n, ready, urgent, in_sr;
  logic [1:0] cas_n;

  dram_refresh_sched #(
    .PAUSE_CYC(P_PAUSE), .INIT_CNT(P_INIT), .REF_INT(P_INT), .SETUP_CYC(P_SET),
    .RASW_CYC(P_RASW), .PRE_CYC(P_PRE), .SR_MIN(P_SRMIN), .SR_PRE(P_SRPRE),
    .BURST_CNT(P_BURST), .DEBT_MAX(P_MAX), .URGENT_LIM(P_LIM)
  ) u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  byte q[$];
  int tcnt = 0, pre_left = 0, low_len = 0, hi_len = 0, fall_t = 0;
  int last_r = 0, prev_r = 0;
  bit model_en = 1, chk_urg = 0, seen_rise = 0, last_s = 0, finished = 0;
  logic prev_ras = 1;
  logic [1:0] prev_cas = 2'b11;

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  // monitor and scoreboard, then the credit model
  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      int qs0;
      bit inflight;
      byte kind, e;
      qs0 = q.size();
      if (chk_urg) chk(urgent == (qs0 > P_LIM), "R9 urgent vs owed", urgent, qs0 > P_LIM);
      if (prev_ras && !ras_n) begin
        chk(prev_cas == 2'b00, "R4 cas low before ras", prev_cas, 0);
        if (seen_rise)
          chk(hi_len >= (last_s ? P_SRPRE : P_PRE) + 1 + P_SET, "R6 R12 precharge",
              hi_len, (last_s ? P_SRPRE : P_PRE) + 1 + P_SET);
        fall_t = cyc; low_len = 0;
      end
      if (!ras_n) begin
        low_len++;
        chk(cas_n == 2'b00 && we_n, "R4 R5 cas low and we high", {cas_n, we_n}, 1);
      end
      if (!prev_ras && ras_n) begin
        kind = (low_len == P_RASW) ? "R" : "S";
        if (q.size() == 0) chk(0, "R3 R10 unexpected cycle", kind, 0);
        else begin
          e = q.pop_front();
          chk(e == kind, "R3 R12 cycle kind", kind, e);
        end
        if (kind == "S") chk(low_len == P_SRMIN, "R11 self refresh low time", low_len, P_SRMIN);
        else begin prev_r = last_r; last_r = fall_t; pre_left = P_PRE; end
        last_s = (kind == "S"); seen_rise = 1; hi_len = 1;
      end else if (ras_n) hi_len++;
      inflight = pre_left > 1;
      if (pre_left > 0) pre_left--;
      if (model_en && ready) begin
        tcnt++;
        if (tcnt == P_INT) begin
          tcnt = 0;
          if (q.size() + int'(inflight) < P_MAX) q.push_back("R");
        end
      end
      prev_ras = ras_n; prev_cas = cas_n;
    end
  end

  initial begin
    for (int i = 0; i < P_INIT; i++) q.push_back("R");
    repeat (5) @(negedge clk);
    chk(!bus_req && !ready && !urgent && !in_sr, "R1 reset flags", {bus_req, ready, urgent, in_sr}, 0);
    chk(ras_n && cas_n == 2'b11 && we_n, "R1 reset strobes", {ras_n, cas_n, we_n}, 15);
    #1 rst_n = 1;
    repeat (P_PAUSE - 1) @(negedge clk);
    chk(bus_req == 0, "R2 silent during pause", bus_req, 0);
    @(negedge clk);
    chk(bus_req == 1, "R2 request after pause", bus_req, 1);
    repeat (10) @(negedge clk);
    chk(ras_n && cas_n == 2'b11 && bus_req, "R3 waits for grant", {ras_n, cas_n, bus_req}, 15);
    #1 bus_gnt = 1;
    do begin @(negedge clk); #1; end while (q.size() != 0);
    chk(ready == 0, "R8 not ready at last rise", ready, 0);
    repeat (2) @(negedge clk);
    chk(ready == 0, "R8 not ready during precharge", ready, 0);
    @(negedge clk);
    chk(ready == 1, "R8 ready after init", ready, 1);

    repeat (200) @(negedge clk);
    chk(last_r - prev_r == P_INT, "R7 refresh spacing", last_r - prev_r, P_INT);

    do begin @(negedge clk); #1; end while (bus_req || !ras_n || pre_left != 0);
    bus_gnt = 0; chk_urg = 1;
    repeat (P_INT * 15) @(negedge clk);
    #1 chk_urg = 0;
    chk(urgent == 1, "R9 urgent after backlog", urgent, 1);
    chk(ras_n && cas_n == 2'b11, "R3 idle while withheld", {ras_n, cas_n}, 7);
    bus_gnt = 1;
    do begin @(negedge clk); #1; end while (q.size() != 0 || pre_left != 0);
    @(negedge clk); #1;
    chk(bus_req == (q.size() != 0), "R10 saturated burst drained", bus_req, q.size() != 0);

    do begin @(negedge clk); #1; end
      while (bus_req || !ras_n || pre_left != 0 || tcnt < 5 || tcnt > 30);
    model_en = 0;
    q.push_back("S");
    for (int i = 0; i < P_BURST; i++) q.push_back("R");
    sr_req = 1;
    do begin @(negedge clk); #1; end while (!in_sr);
    chk(!ras_n && cas_n == 2'b00, "R11 self refresh strobes", {ras_n, cas_n}, 0);
    repeat (3) @(negedge clk);
    #1 sr_req = 0;
    @(negedge clk);
    chk(in_sr == 1, "R11 minimum time held", in_sr, 1);
    do begin @(negedge clk); #1; end while (q.size() != 0 || pre_left != 0);
    repeat (20) @(negedge clk);
    chk(bus_req == 0, "R12 burst complete", bus_req, 0);
    chk(ready == 1, "R8 ready stays high", ready, 1);
    chk(q.size() == 0, "R12 burst count", q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule